// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers the completion and error events of a set of DMA channels and turns them into one level interrupt for software. Every channel can signal four kinds of event: the end of its whole descriptor chain, the end of a descriptor node that asked for notification, and two separate error kinds. Each kind keeps its own latched (raw) bit per channel, an enable (mask) bit per channel and a masked view that is the AND of the two.

A summary view ORs the four masked views per channel, so software can see in one read which channels need attention. The interrupt line is high while any summary bit is set. Software clears latched bits by writing ones to the raw view of a class. When a channel is torn down, software writes that channel's bit to all four raw views. A channel-priority word is also held for software. Writing zero to it means all channels have equal priority, and it has no effect on event handling.

The register port is a simple single-cycle slave. A write lands on the rising edge where the write enable is high. A read returns, in the same cycle, the word selected by the address.

Top module: `dma_irq_aggregator`

## Requirements
- R1: After reset every register reads zero and `irq` is low, so every event starts suppressed.
- R2: A one-cycle pulse on bit i of an event input sets bit i of that class's raw view (chain-complete at byte offset 0x10, node-complete 0x14, error A 0x18, error B 0x1C). The bit stays set until it is cleared.
- R3: Writing a word to a raw view clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When an event pulse and a clearing write hit the same bit in the same cycle, the bit stays set.
- R5: The mask views (0x20, 0x24, 0x28, 0x2C for the four classes in the same order) read back what was written; 1 enables a channel. The masked views (0x30 to 0x3C) read raw AND mask.
- R6: Summary bit i at offset 0x00 is set when channel i has a masked event in any class. `irq` is high while any summary bit is set, and stays high until the last masked event is cleared.
- R7: Writes to the summary and masked views are ignored and change no mask or raw bit.
- R8: The priority word at 0x40 is a full-width read/write register. Writing it changes no event state.
- R9: Bits at and above the channel count read zero. Addresses not listed above, including misaligned ones, read zero and are ignored on write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | DW | Write data |
| reg_we | input | 1 | Write enable, one write per cycle |
| reg_rdata | output | DW | Read data for `reg_addr`, same cycle |
| evt_chain | input | NCH | Per-channel chain-complete pulses |
| evt_node | input | NCH | Per-channel node-complete pulses |
| evt_err_a | input | NCH | Per-channel error class A pulses |
| evt_err_b | input | NCH | Per-channel error class B pulses |
| irq | output | 1 | Interrupt level |

## Verification
The bench builds the block with its defaults: 16 channels on a 32-bit data word. With this setting, an all-ones mask write covers every channel exactly, and bits 31 to 16 stay observable as always-zero read bits. The top channel (15) and the bottom channel (0) both fall within the error-class scenario. The full-width priority word and the narrower event views can also be compared side by side.

// File: rtl/dma_irq_pkg.sv
`timescale 1ns/1ps
package dma_irq_pkg;
    localparam int REG_AW    = 8;
    localparam int NUM_CLASS = 4;

    typedef enum logic [1:0] {
        CLS_CHAIN = 2'd0,
        CLS_NODE  = 2'd1,
        CLS_ERR_A = 2'd2,
        CLS_ERR_B = 2'd3
    } evt_class_e;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_SUM,
        RK_RAW,
        RK_MASK,
        RK_MSKD,
        RK_PRI
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        evt_class_e cls;
    } reg_sel_t;

    localparam logic [3:0] GRP_SUM  = 4'h0;
    localparam logic [3:0] GRP_RAW  = 4'h1;
    localparam logic [3:0] GRP_MASK = 4'h2;
    localparam logic [3:0] GRP_MSKD = 4'h3;
    localparam logic [3:0] GRP_PRI  = 4'h4;

    function automatic reg_sel_t decode_addr(input logic [REG_AW-1:0] a);
        reg_sel_t s;
        s.kind = RK_NONE;
        s.cls  = evt_class_e'(a[3:2]);
        if (a[1:0] == 2'b00) begin
            case (a[7:4])
                GRP_SUM:  if (a[3:2] == 2'b00) s.kind = RK_SUM;
                GRP_RAW:  s.kind = RK_RAW;
                GRP_MASK: s.kind = RK_MASK;
                GRP_MSKD: s.kind = RK_MSKD;
                GRP_PRI:  if (a[3:2] == 2'b00) s.kind = RK_PRI;
                default:  s.kind = RK_NONE;
            endcase
        end
        return s;
    endfunction
endpackage

// File: rtl/irq_evt_class.sv
`timescale 1ns/1ps
module irq_evt_class #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] evt,
    input  logic           clr_we,
    input  logic           mask_we,
    input  logic [NCH-1:0] wbits,
    output logic [NCH-1:0] raw_q,
    output logic [NCH-1:0] mask_q,
    output logic [NCH-1:0] masked
);
    logic [NCH-1:0] clr_bits;

    assign clr_bits = clr_we ? wbits : '0;
    assign masked   = raw_q & mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_bits) | evt;
            if (mask_we) mask_q <= wbits;
        end
    end

    // R2: a pulse latches its bit
    a_r2_event_latches: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((raw_q & $past(evt)) == $past(evt)));

    // R3: without a clearing write no bit drops
    a_r3_hold_without_clear: assert property (@(posedge clk) disable iff (rst)
        (!clr_we) |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

    // R3: bits written as one and not re-raised are gone
    a_r3_ones_clear: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((raw_q & $past(wbits & ~evt)) == '0));

    // R4: event wins over a clear in the same cycle
    a_r4_event_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_we && |(evt & wbits)) |=> ((raw_q & $past(evt & wbits)) == $past(evt & wbits)));
endmodule

// File: rtl/irq_summary.sv
`timescale 1ns/1ps
module irq_summary
    import dma_irq_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic [NCH-1:0] masked [NUM_CLASS],
    output logic [NCH-1:0] summary,
    output logic           irq
);
    logic [NUM_CLASS-1:0] per_ch [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
            assign per_ch[i][c] = masked[c][i];
        end
        assign summary[i] = |per_ch[i];
    end

    assign irq = |summary;
endmodule

// File: rtl/dma_irq_aggregator.sv
`timescale 1ns/1ps
module dma_irq_aggregator
    import dma_irq_pkg::*;
#(
    parameter int NCH = 16,
    parameter int DW  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic              reg_we,
    output logic [DW-1:0]     reg_rdata,
    input  logic [NCH-1:0]    evt_chain,
    input  logic [NCH-1:0]    evt_node,
    input  logic [NCH-1:0]    evt_err_a,
    input  logic [NCH-1:0]    evt_err_b,
    output logic              irq
);
    reg_sel_t       sel;
    logic [NCH-1:0] evt_v    [NUM_CLASS];
    logic [NCH-1:0] raw_v    [NUM_CLASS];
    logic [NCH-1:0] mask_v   [NUM_CLASS];
    logic [NCH-1:0] masked_v [NUM_CLASS];
    logic [NCH-1:0] summary;
    logic [DW-1:0]  pri_q;
    logic [NCH-1:0] narrow_rd;

    assign sel = decode_addr(reg_addr);

    assign evt_v[CLS_CHAIN] = evt_chain;
    assign evt_v[CLS_NODE]  = evt_node;
    assign evt_v[CLS_ERR_A] = evt_err_a;
    assign evt_v[CLS_ERR_B] = evt_err_b;

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
        logic hit;
        assign hit = reg_we && (sel.cls == evt_class_e'(c));
        irq_evt_class #(.NCH(NCH)) u_cls (
            .clk     (clk),
            .rst     (rst),
            .evt     (evt_v[c]),
            .clr_we  (hit && sel.kind == RK_RAW),
            .mask_we (hit && sel.kind == RK_MASK),
            .wbits   (reg_wdata[NCH-1:0]),
            .raw_q   (raw_v[c]),
            .mask_q  (mask_v[c]),
            .masked  (masked_v[c])
        );
    end

    irq_summary #(.NCH(NCH)) u_sum (
        .masked  (masked_v),
        .summary (summary),
        .irq     (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) pri_q <= '0;
        else if (reg_we && sel.kind == RK_PRI) pri_q <= reg_wdata;
    end

    always_comb begin
        case (sel.kind)
            RK_SUM:  narrow_rd = summary;
            RK_RAW:  narrow_rd = raw_v[sel.cls];
            RK_MASK: narrow_rd = mask_v[sel.cls];
            RK_MSKD: narrow_rd = masked_v[sel.cls];
            default: narrow_rd = '0;
        endcase
        reg_rdata = '0;
        if (sel.kind == RK_PRI) reg_rdata = pri_q;
        else reg_rdata[NCH-1:0] = narrow_rd;
    end

    // R1: state is clear right after reset
    a_r1_clean_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (!irq && pri_q == '0 && mask_v[0] == '0 && raw_v[0] == '0));

    // R6: any enabled latched event raises the line
    a_r6_irq_follows_events: assert property (@(posedge clk) disable iff (rst)
        (|((raw_v[0] & mask_v[0]) | (raw_v[1] & mask_v[1]) |
           (raw_v[2] & mask_v[2]) | (raw_v[3] & mask_v[3]))) |-> irq);

    // R6: summary never claims a channel with nothing latched
    a_r6_summary_has_source: assert property (@(posedge clk) disable iff (rst)
        ((summary & ~(raw_v[0] | raw_v[1] | raw_v[2] | raw_v[3])) == '0));

    // R7: writes to the read-only views leave every mask alone
    a_r7_readonly_views: assert property (@(posedge clk) disable iff (rst)
        (reg_we && (sel.kind == RK_MSKD || sel.kind == RK_SUM)) |=>
        ($stable(mask_v[0]) && $stable(mask_v[1]) && $stable(mask_v[2]) && $stable(mask_v[3])));

    // R8: priority word takes the written value
    a_r8_priority_write: assert property (@(posedge clk) disable iff (rst)
        (reg_we && sel.kind == RK_PRI) |=> (pri_q == $past(reg_wdata)));
endmodule

// File: tb/sim_dma_irq_aggregator.sv
`timescale 1ns/1ps
module sim_dma_irq_aggregator;
    localparam int NCH = 16;
    localparam int DW  = 32;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [7:0]     reg_addr = '0;
    logic [DW-1:0]  reg_wdata = '0;
    logic           reg_we = 1'b0;
    logic [DW-1:0]  reg_rdata;
    logic [NCH-1:0] evt_chain = '0, evt_node = '0, evt_err_a = '0, evt_err_b = '0;
    logic           irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dma_irq_aggregator #(.NCH(NCH), .DW(DW)) u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .evt_chain(evt_chain),
        .evt_node(evt_node), .evt_err_a(evt_err_a), .evt_err_b(evt_err_b), .irq(irq)
    );

    localparam logic [7:0] A_SUM = 8'h00, A_PRI = 8'h40;
    function automatic logic [7:0] a_raw(int c);  return 8'(8'h10 + 4*c); endfunction
    function automatic logic [7:0] a_mask(int c); return 8'(8'h20 + 4*c); endfunction
    function automatic logic [7:0] a_mskd(int c); return 8'(8'h30 + 4*c); endfunction

    task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse(input logic [NCH-1:0] c0, c1, c2, c3);
        @(negedge clk);
        evt_chain = c0; evt_node = c1; evt_err_a = c2; evt_err_b = c3;
        @(negedge clk);
        evt_chain = '0; evt_node = '0; evt_err_a = '0; evt_err_b = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [DW-1:0] exp, input string tag);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr %h: got %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        #1;
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s irq: got %b expected %b", tag, irq, exp);
        end
    endtask

    task automatic t_reset();
        rd(A_SUM, 0, "R1 summary");
        rd(a_raw(0), 0, "R1 raw chain");
        rd(a_mask(3), 0, "R1 mask err_b");
        rd(A_PRI, 0, "R1 priority");
        chk_irq(1'b0, "R1");
    endtask

    task automatic t_raw_set();
        pulse(16'h0004, 0, 0, 0);
        rd(a_raw(0), 32'h4, "R2 raw latched");
        rd(a_mskd(0), 32'h0, "R5 masked while disabled");
        chk_irq(1'b0, "R5 masked event silent");
    endtask

    task automatic t_mask();
        wr(a_mask(0), 32'hFFFF_FFFF);
        rd(a_mask(0), 32'h0000_FFFF, "R9 mask upper bits zero");
        rd(a_mskd(0), 32'h4, "R5 masked view");
        rd(A_SUM, 32'h4, "R6 summary");
        chk_irq(1'b1, "R6 irq raised");
    endtask

    task automatic t_w1c();
        pulse(0, 16'h0030, 0, 0);
        wr(a_mask(1), 32'h10);
        rd(a_mskd(1), 32'h10, "R5 node masked");
        wr(a_raw(1), 32'h20);
        rd(a_raw(1), 32'h10, "R3 one clears");
        wr(a_raw(1), 32'h0);
        rd(a_raw(1), 32'h10, "R3 zero keeps");
        rd(A_SUM, 32'h14, "R6 summary two classes");
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        evt_chain = 16'h0008;
        reg_addr = a_raw(0); reg_wdata = 32'h0C; reg_we = 1'b1;
        @(negedge clk);
        evt_chain = '0; reg_we = 1'b0;
        rd(a_raw(0), 32'h8, "R4 event beats clear");
        rd(A_SUM, 32'h18, "R4 summary");
    endtask

    task automatic t_readonly();
        wr(a_mskd(0), 32'h0);
        wr(A_SUM, 32'h0);
        rd(a_mskd(0), 32'h8, "R7 masked view unchanged");
        rd(A_SUM, 32'h18, "R7 summary unchanged");
        rd(a_mask(0), 32'hFFFF, "R7 mask unchanged");
    endtask

    task automatic t_errors();
        wr(a_mask(2), 32'hFFFF);
        wr(a_mask(3), 32'hFFFF);
        pulse(0, 0, 16'h8000, 16'h0001);
        rd(a_raw(2), 32'h8000, "R2 error A channel 15");
        rd(a_raw(3), 32'h0001, "R2 error B channel 0");
        rd(A_SUM, 32'h8019, "R6 summary all classes");
        wr(a_raw(0), 32'hFFFF);
        rd(A_SUM, 32'h8011, "R6 after chain clear");
        wr(a_raw(1), 32'hFFFF);
        wr(a_raw(2), 32'hFFFF);
        rd(A_SUM, 32'h0001, "R6 one left");
        chk_irq(1'b1, "R6 irq held until last clear");
        wr(a_raw(3), 32'hFFFF);
        rd(A_SUM, 32'h0, "R6 all cleared");
        chk_irq(1'b0, "R6 irq dropped");
    endtask

    task automatic t_pri();
        wr(A_PRI, 32'hDEAD_BEEF);
        rd(A_PRI, 32'hDEAD_BEEF, "R8 priority readback");
        rd(A_SUM, 32'h0, "R8 no event effect");
        pulse(16'h0001, 0, 0, 0);
        rd(a_raw(0), 32'h1, "R8 events still latch");
        wr(A_PRI, 32'h0);
        rd(A_PRI, 32'h0, "R8 priority zero");
    endtask

    task automatic t_unmapped();
        rd(8'h44, 0, "R9 unmapped 0x44");
        rd(8'h0C, 0, "R9 unmapped 0x0C");
        rd(8'h12, 0, "R9 misaligned 0x12");
        wr(8'h44, 32'h1234_5678);
        wr(8'h22, 32'h0);
        rd(A_PRI, 0, "R9 write to hole ignored");
        rd(a_mask(0), 32'hFFFF, "R9 misaligned write ignored");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_raw_set();
        t_mask();
        t_w1c();
        t_same_cycle();
        t_readonly();
        t_errors();
        t_pri();
        t_unmapped();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule